// File: doc/BRIEF.md
# Pipeline operand forwarding unit

This block picks, for a five-stage in-order pipeline, the source of each value an instruction consumes in the middle stages. It compares the two source register numbers of the instruction in EX, and the store-data register of a store in MEM, with the destination numbers and write flags held in the EX/MEM and MEM/WB pipeline registers. It returns multiplexer select codes that steer ALU input A, ALU input B and the data-memory write-data input. These selects choose between the register file and results still travelling down the pipe.

The register file is written early in a cycle and read late in it. An instruction three places behind a writer therefore reads the fresh value from the file, and needs no path here. The block adds a path from MEM/WB into the store-data port. With it, a store in MEM can take a just-loaded value and needs no stall. The logic is purely combinational. Stall control, the register file and the datapath multiplexers are outside it.

Top module: `fwd_unit`

## Requirements
- R1: When the EX/MEM producer writes (`exmem_we_i`=1) a nonzero register equal to an EX source, that operand's select is 2'b01.
- R2: When only the MEM/WB producer writes a nonzero register equal to an EX source, that operand's select is 2'b10.
- R3: When both producers match the same EX source, the select is 2'b01, because EX/MEM holds the newer result.
- R4: A producer whose write enable is 0 never causes forwarding, even when its register numbers match.
- R5: A producer whose destination is register 0 never causes forwarding.
- R6: `st_sel_o` is 1 exactly when `mem_store_i`=1, `memwb_we_i`=1, `memwb_rd_i` is nonzero and equals `mem_rs2_i`. In every other case it is 0, which selects the register file.
- R7: An operand with no valid match selects the register file (2'b00). This includes a source written by an instruction three or more places ahead.
- R8: All selects follow their inputs within the same cycle, with no register on the path. The code 2'b11 never appears.
- R9: The selects for operand A and operand B are decided independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs1_i | input | REG_W | First source register of the instruction in EX |
| ex_rs2_i | input | REG_W | Second source register of the instruction in EX |
| mem_store_i | input | 1 | Instruction in MEM is a store |
| mem_rs2_i | input | REG_W | Store-data register of the instruction in MEM |
| exmem_rd_i | input | REG_W | Destination held in EX/MEM |
| exmem_we_i | input | 1 | Register write enable held in EX/MEM |
| memwb_rd_i | input | REG_W | Destination held in MEM/WB |
| memwb_we_i | input | 1 | Register write enable held in MEM/WB |
| sel_a_o | output | 2 | ALU input A select: 00 register file, 01 EX/MEM, 10 MEM/WB |
| sel_b_o | output | 2 | ALU input B select, same encoding |
| st_sel_o | output | 1 | Store data select: 0 register file, 1 MEM/WB |

## Verification
Every select is a combinational function of the current inputs, so each result is due in the same cycle that its stimulus is applied. No cycle of latency needs to be counted. The bench drives a new input set just after a falling clock edge and samples the three selects one nanosecond later. The sample is taken well before the next rising edge, so a stale or registered output would be caught. Directed cases cover priority, the write-enable and register-0 gates, and the store path. A randomized sweep then compares every select against a reference model written from the requirements.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    SEL_RF    = 2'b00,
    SEL_EXMEM = 2'b01,
    SEL_MEMWB = 2'b10
  } opsel_e;
endpackage

// File: rtl/fwd_hit.sv
module fwd_hit #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src_i,
  input  logic [REG_W-1:0] dst_i,
  input  logic             we_i,
  output logic             hit_o
);
  // register 0 is hardwired, never a real producer
  assign hit_o = we_i && (dst_i != '0) && (dst_i == src_i);
endmodule

// File: rtl/fwd_opnd_sel.sv
module fwd_opnd_sel
  import fwd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src_i,
  input  logic [REG_W-1:0] exmem_rd_i,
  input  logic             exmem_we_i,
  input  logic [REG_W-1:0] memwb_rd_i,
  input  logic             memwb_we_i,
  output opsel_e           sel_o
);
  logic hit_em, hit_mw;

  fwd_hit #(.REG_W(REG_W)) i_hit_em (
    .src_i(src_i), .dst_i(exmem_rd_i), .we_i(exmem_we_i), .hit_o(hit_em)
  );
  fwd_hit #(.REG_W(REG_W)) i_hit_mw (
    .src_i(src_i), .dst_i(memwb_rd_i), .we_i(memwb_we_i), .hit_o(hit_mw)
  );

  // newer result wins
  always_comb begin
    if (hit_em)      sel_o = SEL_EXMEM;
    else if (hit_mw) sel_o = SEL_MEMWB;
    else             sel_o = SEL_RF;
  end
endmodule

// File: rtl/fwd_store_sel.sv
module fwd_store_sel #(
  parameter int REG_W = 5
) (
  input  logic             store_i,
  input  logic [REG_W-1:0] src_i,
  input  logic [REG_W-1:0] memwb_rd_i,
  input  logic             memwb_we_i,
  output logic             sel_o
);
  logic hit_mw;

  fwd_hit #(.REG_W(REG_W)) i_hit_mw (
    .src_i(src_i), .dst_i(memwb_rd_i), .we_i(memwb_we_i), .hit_o(hit_mw)
  );

  assign sel_o = store_i && hit_mw;
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] ex_rs1_i,
  input  logic [REG_W-1:0] ex_rs2_i,
  input  logic             mem_store_i,
  input  logic [REG_W-1:0] mem_rs2_i,
  input  logic [REG_W-1:0] exmem_rd_i,
  input  logic             exmem_we_i,
  input  logic [REG_W-1:0] memwb_rd_i,
  input  logic             memwb_we_i,
  output logic [1:0]       sel_a_o,
  output logic [1:0]       sel_b_o,
  output logic             st_sel_o
);
  localparam int NUM_OPND = 2;

  logic [REG_W-1:0] src [NUM_OPND];
  opsel_e           sel [NUM_OPND];

  assign src[0] = ex_rs1_i;
  assign src[1] = ex_rs2_i;

  for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
    fwd_opnd_sel #(.REG_W(REG_W)) i_opnd (
      .src_i      (src[g]),
      .exmem_rd_i (exmem_rd_i),
      .exmem_we_i (exmem_we_i),
      .memwb_rd_i (memwb_rd_i),
      .memwb_we_i (memwb_we_i),
      .sel_o      (sel[g])
    );

    always_comb begin
      if (sel[g] == SEL_EXMEM)
        AST_EXMEM_SRC: assert (exmem_we_i && exmem_rd_i == src[g]); // R1
      if (sel[g] == SEL_MEMWB)
        AST_MEMWB_NEWER: assert (memwb_we_i && memwb_rd_i == src[g] &&
                                 !(exmem_we_i && exmem_rd_i == src[g])); // R3
      if (sel[g] != SEL_RF)
        AST_NO_R0: assert (src[g] != '0); // R5
      AST_SEL_LEGAL: assert (sel[g] != opsel_e'(2'b11)); // R8
    end
  end

  fwd_store_sel #(.REG_W(REG_W)) i_st (
    .store_i    (mem_store_i),
    .src_i      (mem_rs2_i),
    .memwb_rd_i (memwb_rd_i),
    .memwb_we_i (memwb_we_i),
    .sel_o      (st_sel_o)
  );

  always_comb begin
    if (st_sel_o)
      AST_ST_PATH: assert (mem_store_i && memwb_we_i && mem_rs2_i != '0 &&
                           memwb_rd_i == mem_rs2_i); // R6
  end

  assign sel_a_o = sel[0];
  assign sel_b_o = sel[1];
endmodule

// File: tb/test_fwd_unit.sv
`timescale 1ns/1ps
module test_fwd_unit;
  localparam int REG_W = 5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [REG_W-1:0] ex_rs1, ex_rs2, mem_rs2, exmem_rd, memwb_rd;
  logic             mem_store, exmem_we, memwb_we;
  logic [1:0]       sel_a, sel_b;
  logic             st_sel;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  fwd_unit #(.REG_W(REG_W)) i_fwd_unit (
    .ex_rs1_i(ex_rs1), .ex_rs2_i(ex_rs2),
    .mem_store_i(mem_store), .mem_rs2_i(mem_rs2),
    .exmem_rd_i(exmem_rd), .exmem_we_i(exmem_we),
    .memwb_rd_i(memwb_rd), .memwb_we_i(memwb_we),
    .sel_a_o(sel_a), .sel_b_o(sel_b), .st_sel_o(st_sel)
  );

  function automatic logic [1:0] ref_sel(input logic [REG_W-1:0] rs);
    if (exmem_we && exmem_rd != 0 && exmem_rd == rs) return 2'b01;
    if (memwb_we && memwb_rd != 0 && memwb_rd == rs) return 2'b10;
    return 2'b00;
  endfunction

  function automatic logic ref_st();
    return mem_store && memwb_we && memwb_rd != 0 && memwb_rd == mem_rs2;
  endfunction

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  // drive after falling edge, sample 1 ns later: same-cycle result
  task automatic apply(input logic [REG_W-1:0] a, b, input logic st, input logic [REG_W-1:0] srs,
                       input logic [REG_W-1:0] erd, input logic ewe,
                       input logic [REG_W-1:0] mrd, input logic mwe);
    @(negedge clk);
    ex_rs1 = a; ex_rs2 = b; mem_store = st; mem_rs2 = srs;
    exmem_rd = erd; exmem_we = ewe; memwb_rd = mrd; memwb_we = mwe;
    #1;
  endtask

  task automatic t_idle();
    apply(0, 0, 0, 0, 0, 0, 0, 0);
    chk("R7 idle A", sel_a, 2'b00);
    chk("R7 idle B", sel_b, 2'b00);
    chk("R6 idle st", {1'b0, st_sel}, 2'b00);
  endtask

  task automatic t_exmem();
    apply(3, 9, 0, 0, 3, 1, 0, 0);
    chk("R1 A from EX/MEM", sel_a, 2'b01);
    chk("R9 B untouched", sel_b, 2'b00);
    apply(9, 3, 0, 0, 3, 1, 0, 0);
    chk("R1 B from EX/MEM", sel_b, 2'b01);
  endtask

  task automatic t_memwb();
    apply(7, 7, 0, 0, 4, 1, 7, 1);
    chk("R2 A from MEM/WB", sel_a, 2'b10);
    chk("R2 B from MEM/WB", sel_b, 2'b10);
  endtask

  task automatic t_both();
    apply(12, 12, 0, 0, 12, 1, 12, 1);
    chk("R3 A priority", sel_a, 2'b01);
    chk("R3 B priority", sel_b, 2'b01);
    apply(12, 5, 0, 0, 12, 0, 12, 1);
    chk("R3 EX/MEM off falls to MEM/WB", sel_a, 2'b10);
  endtask

  task automatic t_we_off();
    apply(6, 6, 1, 6, 6, 0, 6, 0);
    chk("R4 A we off", sel_a, 2'b00);
    chk("R4 B we off", sel_b, 2'b00);
    chk("R4 st we off", {1'b0, st_sel}, 2'b00);
  endtask

  task automatic t_r0();
    apply(0, 0, 1, 0, 0, 1, 0, 1);
    chk("R5 A reg0", sel_a, 2'b00);
    chk("R5 B reg0", sel_b, 2'b00);
    chk("R5 st reg0", {1'b0, st_sel}, 2'b00);
  endtask

  task automatic t_store();
    apply(1, 2, 1, 8, 0, 0, 8, 1);
    chk("R6 load to store", {1'b0, st_sel}, 2'b01);
    apply(1, 2, 0, 8, 0, 0, 8, 1);
    chk("R6 not a store", {1'b0, st_sel}, 2'b00);
    apply(1, 2, 1, 8, 8, 1, 9, 1);
    chk("R6 EX/MEM not used for store", {1'b0, st_sel}, 2'b00);
  endtask

  task automatic t_third();
    // writer three ahead is already in the file; only unrelated producers here
    apply(10, 11, 1, 10, 20, 1, 21, 1);
    chk("R7 A file", sel_a, 2'b00);
    chk("R7 B file", sel_b, 2'b00);
    chk("R7 st file", {1'b0, st_sel}, 2'b00);
  endtask

  task automatic t_indep();
    apply(14, 15, 0, 0, 14, 1, 15, 1);
    chk("R9 A EX/MEM", sel_a, 2'b01);
    chk("R9 B MEM/WB", sel_b, 2'b10);
    apply(15, 14, 0, 0, 14, 1, 15, 1);
    chk("R9 A MEM/WB swap", sel_a, 2'b10);
    chk("R9 B EX/MEM swap", sel_b, 2'b01);
  endtask

  task automatic t_random();
    // small register pool to get frequent matches
    for (int i = 0; i < 400; i++) begin
      apply($urandom % 4, $urandom % 4, 1'($urandom), $urandom % 4,
            $urandom % 4, 1'($urandom), $urandom % 4, 1'($urandom));
      chk("R8 random A", sel_a, ref_sel(ex_rs1));
      chk("R8 random B", sel_b, ref_sel(ex_rs2));
      chk("R8 random st", {1'b0, st_sel}, {1'b0, ref_st()});
    end
  endtask

  initial begin
    #100000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_idle();
    t_exmem();
    t_memwb();
    t_both();
    t_we_off();
    t_r0();
    t_store();
    t_third();
    t_indep();
    t_random();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule